// File: doc/BRIEF.md
# LED Matrix Character Scan Driver

This block lights a horizontal strip of 5-column by 7-row LED character cells with a single shared set of column lines. It does so by time-division multiplexing. At any moment exactly one row code and one cell code are decoded. All cells share the column data, but only the cell whose active-low enable is asserted passes that data to its anodes. The active-low row output, once inverted off-chip, sinks the selected row. The scan visits every cell-and-row pair, cell by cell within a row, then moves to the next row. After row 6 it returns to row 0.

A host loads column bitmaps through a one-cycle write port into a shadow half of a double-buffered frame store. The shadow half becomes visible only when a whole frame has been scanned. A scroll offset moves the displayed window across the strip in steps of one pixel column. The offset is also taken only at the frame boundary, so no frame ever shows two offsets. The block presents a 12-bit drive word as well as the decoded enables. The drive word carries the row code, the column data and the cell code. Each slot lasts a programmable number of cycles, and a single blank cycle separates consecutive slots to suppress ghosting.

Top module: `ledscan_top`

## Requirements
- R1: While `rst_n` is low, every bit of `row_en_n` and `cell_en_n` is high. The first slot lit after reset is row 0, cell 0.
- R2: At most one bit of `row_en_n` and at most one bit of `cell_en_n` are low at any time. `row_en_n[7]` and every `cell_en_n` bit at index NCELLS or above never go low.
- R3: Slots follow the order (row 0, cell 0), (row 0, cell 1) … (row 0, cell NCELLS-1), (row 1, cell 0) … (row 6, cell NCELLS-1). The order then starts again at row 0, cell 0.
- R4: Each slot holds its enables for `dwell` cycles, where a value of 0 acts as 1. Exactly one cycle follows in which all enables are high and `drive_word[7:3]` is zero.
- R5: While a slot is lit, `drive_word[2:0]` carries the row code and `drive_word[11:8]` carries the cell code. The low bit of `row_en_n` and the low bit of `cell_en_n` sit at the positions given by those codes.
- R6: With a scroll offset of 0, `drive_word[3+k]` in a lit slot equals bit k of the stored pattern for that cell and row, for k = 0 to 4. A 1 lights the LED.
- R7: Each write (`wr_en` high, `wr_row` from 0 to 6) goes to the hidden buffer. It becomes visible from the first slot of the frame that follows the frame in which it was written. A frame with no writes leaves the shown image unchanged.
- R8: With a scroll offset s, column k of cell c shows strip column (5c + k + s) mod (5·NCELLS). Strip column 5c' + k' is bit k' of cell c'. An input s at or above 5·NCELLS is reduced by 5·NCELLS.
- R9: A change on `scroll` does not affect the frame in progress. It takes effect at the next frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dwell | input | DWELL_W | Cycles each slot stays lit (0 acts as 1) |
| scroll | input | SHIFT_W | Scroll offset in pixel columns |
| wr_en | input | 1 | Host write strobe |
| wr_cell | input | 4 | Cell written |
| wr_row | input | 3 | Row written |
| wr_cols | input | 5 | Column bitmap, bit k = column k |
| drive_word | output | 12 | {cell code, column data, row code} |
| row_en_n | output | 8 | Decoded active-low row enables |
| cell_en_n | output | 16 | Decoded active-low cell enables |

## Verification
The hardest situation to reach is the frame boundary acting as a sampling point. A host write or a scroll change must stay invisible for the rest of the current frame and appear whole in the next one. The stimulus first locks onto the start of slot (row 1, cell 0). It then loads a second image, or changes the offset, and samples the slot still in progress against the old image. Finally it walks the whole following frame slot by slot against the new one. Offsets of 7, 19 and an out-of-range 25 drive the window across cell borders and the strip's wrap point.

// File: rtl/ledscan_pkg.sv
package ledscan_pkg;
  localparam int COLS        = 5;
  localparam int ROWS        = 7;
  localparam int ROW_CODE_W  = 3;
  localparam int CELL_CODE_W = 4;
  localparam int ROW_OUTS    = 1 << ROW_CODE_W;
  localparam int MAX_CELLS   = 1 << CELL_CODE_W;
  localparam int WORD_W      = ROW_CODE_W + COLS + CELL_CODE_W;
endpackage

// File: rtl/ledscan_dec.sv
module ledscan_dec #(
  parameter int CODE_W = 3,
  parameter int N_OUT  = 8,
  parameter int N_USED = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              en,
  output logic [N_OUT-1:0]  out_n
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    if (i < N_USED) begin : g_used
      assign out_n[i] = !(en && (code == CODE_W'(i)));
    end else begin : g_unused
      assign out_n[i] = 1'b1;
    end
  end

  // R2
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~out_n));
endmodule

// File: rtl/ledscan_seq.sv
module ledscan_seq
  import ledscan_pkg::*;
#(
  parameter int NCELLS  = 4,
  parameter int DWELL_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DWELL_W-1:0]     dwell,
  output logic [ROW_CODE_W-1:0]  row_code,
  output logic [CELL_CODE_W-1:0] cell_code,
  output logic                   lit,
  output logic                   frame_end
);
  localparam logic [ROW_CODE_W-1:0]  LAST_ROW  = ROW_CODE_W'(ROWS - 1);
  localparam logic [CELL_CODE_W-1:0] LAST_CELL = CELL_CODE_W'(NCELLS - 1);

  logic                   lit_q, lit_d;
  logic [ROW_CODE_W-1:0]  row_q, row_d;
  logic [CELL_CODE_W-1:0] cell_q, cell_d;
  logic [DWELL_W-1:0]     cnt_q, cnt_d, hold_last;
  logic                   last_tick, step_en;

  always_comb begin
    hold_last = (dwell == '0) ? '0 : dwell - 1'b1;
    last_tick = lit_q && (cnt_q >= hold_last);
    step_en   = last_tick;
    frame_end = last_tick && (row_q == LAST_ROW) && (cell_q == LAST_CELL);
    lit_d     = !lit_q || !last_tick;
    cnt_d     = (lit_q && !last_tick) ? cnt_q + 1'b1 : '0;
    if (cell_q == LAST_CELL) begin
      cell_d = '0;
      row_d  = (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
    end else begin
      cell_d = cell_q + 1'b1;
      row_d  = row_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lit_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lit_q <= lit_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      cell_q <= '0;
    end else if (step_en) begin
      row_q  <= row_d;
      cell_q <= cell_d;
    end
  end

  assign row_code  = row_q;
  assign cell_code = cell_q;
  assign lit       = lit_q;

  // R4
  slot_end_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> !lit_q);
  // R4
  blank_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lit_q |=> lit_q);
  // R4
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lit_q && !last_tick) |=> (lit_q && $stable(row_q) && $stable(cell_q)));
  // R3
  scan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_q <= LAST_ROW) && (cell_q <= LAST_CELL));
endmodule

// File: rtl/ledscan_fmem.sv
module ledscan_fmem
  import ledscan_pkg::*;
#(
  parameter int NCELLS  = 4,
  parameter int SHIFT_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CELL_CODE_W-1:0] wr_cell,
  input  logic [ROW_CODE_W-1:0]  wr_row,
  input  logic [COLS-1:0]        wr_cols,
  input  logic                   frame_end,
  input  logic [ROW_CODE_W-1:0]  rd_row,
  input  logic [CELL_CODE_W-1:0] rd_cell,
  input  logic [SHIFT_W-1:0]     shift,
  output logic [COLS-1:0]        rd_cols
);
  localparam int STRIP = NCELLS * COLS;

  logic [COLS-1:0]    mem_q [2][MAX_CELLS][ROWS];
  logic               bank_q, bank_d, dirty_q, dirty_d;
  logic               wr_ok, swap;
  logic [STRIP-1:0]   strip;
  logic [2*STRIP-1:0] dbl;
  int                 base;

  always_comb begin
    wr_ok   = wr_en && (wr_row < ROW_CODE_W'(ROWS));
    swap    = frame_end && dirty_q;
    bank_d  = swap ? !bank_q : bank_q;
    dirty_d = wr_ok ? 1'b1 : (swap ? 1'b0 : dirty_q);
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[!bank_q][wr_cell][wr_row] <= wr_cols;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      bank_q  <= bank_d;
      dirty_q <= dirty_d;
    end
  end

  always_comb begin
    for (int c = 0; c < NCELLS; c++) begin
      strip[c*COLS +: COLS] = mem_q[bank_q][CELL_CODE_W'(c)][rd_row];
    end
    dbl     = {strip, strip};
    base    = int'(rd_cell) * COLS + int'(shift);
    rd_cols = dbl[base +: COLS];
  end

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(bank_q));
  // R7
  idle_frame_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !dirty_q) |=> $stable(bank_q));
endmodule

// File: rtl/ledscan_top.sv
module ledscan_top
  import ledscan_pkg::*;
#(
  parameter int NCELLS  = 4,
  parameter int DWELL_W = 8,
  parameter int SHIFT_W = $clog2(NCELLS * 5)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DWELL_W-1:0]     dwell,
  input  logic [SHIFT_W-1:0]     scroll,
  input  logic                   wr_en,
  input  logic [CELL_CODE_W-1:0] wr_cell,
  input  logic [ROW_CODE_W-1:0]  wr_row,
  input  logic [COLS-1:0]        wr_cols,
  output logic [WORD_W-1:0]      drive_word,
  output logic [ROW_OUTS-1:0]    row_en_n,
  output logic [MAX_CELLS-1:0]   cell_en_n
);
  localparam int STRIP = NCELLS * COLS;

  logic [ROW_CODE_W-1:0]  row_code;
  logic [CELL_CODE_W-1:0] cell_code;
  logic                   lit, frame_end;
  logic [COLS-1:0]        rd_cols, cols_out;
  logic [SHIFT_W-1:0]     scroll_q, scroll_fold;

  ledscan_seq #(.NCELLS(NCELLS), .DWELL_W(DWELL_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .dwell(dwell),
    .row_code(row_code), .cell_code(cell_code),
    .lit(lit), .frame_end(frame_end)
  );

  ledscan_fmem #(.NCELLS(NCELLS), .SHIFT_W(SHIFT_W)) fmem_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_cell(wr_cell), .wr_row(wr_row), .wr_cols(wr_cols),
    .frame_end(frame_end),
    .rd_row(row_code), .rd_cell(cell_code), .shift(scroll_q),
    .rd_cols(rd_cols)
  );

  ledscan_dec #(.CODE_W(ROW_CODE_W), .N_OUT(ROW_OUTS), .N_USED(ROWS)) row_dec_i (
    .clk(clk), .rst_n(rst_n), .code(row_code), .en(lit), .out_n(row_en_n)
  );

  ledscan_dec #(.CODE_W(CELL_CODE_W), .N_OUT(MAX_CELLS), .N_USED(NCELLS)) cell_dec_i (
    .clk(clk), .rst_n(rst_n), .code(cell_code), .en(lit), .out_n(cell_en_n)
  );

  always_comb begin
    if (int'(scroll) >= STRIP) scroll_fold = SHIFT_W'(int'(scroll) - STRIP);
    else                       scroll_fold = scroll;
    cols_out   = lit ? rd_cols : '0;
    drive_word = {cell_code, cols_out, row_code};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         scroll_q <= '0;
    else if (frame_end) scroll_q <= scroll_fold;
  end

  // R9
  scroll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(scroll_q));
  // R2
  lit_pairing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~row_en_n) == $countones(~cell_en_n)));
endmodule

// File: tb/ledscan_top_tb_top.sv
`timescale 1ns/1ps
module ledscan_top_tb_top;
  localparam int NC = 4;
  localparam int NSLOT = 7 * NC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  dwell;
  logic [4:0]  scroll;
  logic        wr_en;
  logic [3:0]  wr_cell;
  logic [2:0]  wr_row;
  logic [4:0]  wr_cols;
  logic [11:0] drive_word;
  logic [7:0]  row_en_n;
  logic [15:0] cell_en_n;

  int checks = 0;
  int errors = 0;
  logic [4:0] fa [16][7];
  logic [4:0] fb [16][7];

  always #4 clk = ~clk;

  ledscan_top dut_i (
    .clk(clk), .rst_n(rst_n), .dwell(dwell), .scroll(scroll),
    .wr_en(wr_en), .wr_cell(wr_cell), .wr_row(wr_row), .wr_cols(wr_cols),
    .drive_word(drive_word), .row_en_n(row_en_n), .cell_en_n(cell_en_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int low_idx(input logic [15:0] v);
    int n = 0;
    int idx = -1;
    for (int i = 0; i < 16; i++) if (v[i] == 1'b0) begin n++; idx = i; end
    if (n > 1) return -2;
    return idx;
  endfunction

  function automatic logic [4:0] win(input logic [4:0] m [16][7],
                                     input int c, input int r, input int s);
    logic [4:0] w;
    for (int k = 0; k < 5; k++) begin
      int g = (c * 5 + k + s) % (NC * 5);
      w[k] = m[g / 5][r][g % 5];
    end
    return w;
  endfunction

  function automatic bit is_blank();
    return (row_en_n == 8'hFF) && (cell_en_n == 16'hFFFF);
  endfunction

  task automatic load(input logic [4:0] m [16][7]);
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < 7; r++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_cell = 4'(c); wr_row = 3'(r); wr_cols = m[c][r];
      end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sync_slot(input int tr, input int tc);
    bit prev_blank = is_blank();
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (low_idx({8'hFF, row_en_n}) == tr && low_idx(cell_en_n) == tc && prev_blank) return;
      prev_blank = is_blank();
    end
    chk(1'b0, "R3", "slot never reached", tr * 16 + tc, -1);
  endtask

  task automatic check_now(input logic [4:0] m [16][7], input int s, input string req);
    int r, c;
    for (int n = 0; n < 50 && is_blank(); n++) @(negedge clk);
    r = low_idx({8'hFF, row_en_n});
    c = low_idx(cell_en_n);
    if (r < 0 || c < 0) chk(1'b0, req, "no lit slot", r, 0);
    else chk(drive_word[7:3] == win(m, c, r, s), req, "columns mid-frame",
             int'(drive_word[7:3]), int'(win(m, c, r, s)));
  endtask

  task automatic walk_frame(input logic [4:0] m [16][7], input int s,
                            input int deff, input string req);
    sync_slot(0, 0);
    for (int si = 0; si < NSLOT; si++) begin
      int er = si / NC;
      int ec = si % NC;
      int r = low_idx({8'hFF, row_en_n});
      int c = low_idx(cell_en_n);
      int len = 1;
      logic [4:0]  expw = win(m, ec, er, s);
      logic [7:0]  cur_r = row_en_n;
      logic [15:0] cur_c = cell_en_n;
      logic [11:0] cur_w = drive_word;
      chk(r == er && c == ec, "R3", "slot order row*16+cell", r * 16 + c, er * 16 + ec);
      chk(row_en_n[7] && (&cell_en_n[15:NC]), "R2", "unused enable low",
          int'(cell_en_n), 16'hFFFF);
      chk(drive_word[2:0] == 3'(er) && drive_word[11:8] == 4'(ec), "R5",
          "code fields", int'({drive_word[11:8], drive_word[2:0]}), ec * 8 + er);
      chk(drive_word[7:3] == expw, req, "columns", int'(drive_word[7:3]), int'(expw));
      for (int n = 0; n < 300; n++) begin
        @(negedge clk);
        if (row_en_n == cur_r && cell_en_n == cur_c && drive_word == cur_w) len++;
        else break;
      end
      chk(len == deff, "R4", "slot length", len, deff);
      chk(is_blank() && drive_word[7:3] == 5'd0, "R4", "blank cycle",
          int'(drive_word[7:3]), 0);
      if (si < NSLOT - 1) begin
        @(negedge clk);
        chk(!is_blank(), "R4", "second blank cycle", 1, 0);
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(row_en_n == 8'hFF, "R1", "row enables in reset", int'(row_en_n), 8'hFF);
    chk(cell_en_n == 16'hFFFF, "R1", "cell enables in reset", int'(cell_en_n), 16'hFFFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk(low_idx({8'hFF, row_en_n}) == 0 && low_idx(cell_en_n) == 0, "R1",
        "first slot after reset", low_idx(cell_en_n), 0);
  endtask

  task automatic t_basic();
    load(fa);
    walk_frame(fa, 0, 3, "R6");
  endtask

  task automatic t_dwell();
    dwell = 8'd1; walk_frame(fa, 0, 1, "R6");
    dwell = 8'd0; walk_frame(fa, 0, 1, "R6");
    dwell = 8'd6; walk_frame(fa, 0, 6, "R6");
    dwell = 8'd3;
  endtask

  task automatic t_shadow();
    sync_slot(1, 0);
    load(fb);
    check_now(fa, 0, "R7");
    walk_frame(fb, 0, 3, "R7");
    walk_frame(fb, 0, 3, "R7");
  endtask

  task automatic t_scroll();
    sync_slot(1, 0); scroll = 5'd7;  check_now(fb, 0, "R9");
    walk_frame(fb, 7, 3, "R8");
    sync_slot(1, 0); scroll = 5'd19; check_now(fb, 7, "R9");
    walk_frame(fb, 19, 3, "R8");
    sync_slot(1, 0); scroll = 5'd25; check_now(fb, 19, "R9");
    walk_frame(fb, 5, 3, "R8");
    scroll = 5'd0;
  endtask

  initial begin
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 7; r++) begin
        fa[c][r] = 5'((c * 5 + r * 11 + 3) ^ (r << 2));
        fb[c][r] = 5'((c * 13 + r * 7 + 9) ^ (c << 1));
      end
    dwell = 8'd3; scroll = 5'd0;
    wr_en = 1'b0; wr_cell = '0; wr_row = '0; wr_cols = '0;
    t_reset();
    t_basic();
    t_dwell();
    t_shadow();
    t_scroll();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule